// File: doc/BRIEF.md
# Hybrid Local/Global Conditional Branch Predictor

This block predicts the direction of conditional branches by combining two
predictors of different character and letting a third table decide which one
to trust. The first predictor keeps one shared 12-bit shift register of recent
branch outcomes and uses it to select a 2-bit counter from a 4096-entry table.
The second predictor has two levels. A 1024-entry table, addressed by program
counter bits, holds a 10-bit outcome history for each branch. That history then
selects a 3-bit counter from a further 1024-entry table. A 4096-entry table of
2-bit selector counters is addressed by the shared history and chooses which of
the two predictions becomes the output.

A fetch stage presents a program counter on the lookup side and reads back the
prediction in the same cycle, together with a flag that shows which component
was chosen. When the branch resolves, the execute stage presents the branch's
program counter and its real outcome on the update side. That update trains
both component counters. It moves the selector only when exactly one of the two
components was right. It also shifts the outcome into the shared history and
into the history of that branch. The total storage is 4K×2 + 4K×2 + 1K×10 +
1K×3 bits, roughly 29K bits.

Top module: `tourney_bp`

## Requirements
- R1: After reset every history is zero, every 2-bit direction counter holds 1, every 3-bit counter holds 3 and every selector counter holds 1. As a result every lookup returns not-taken with `lk_use_global` = 0.
- R2: On an accepted update, the shared history shifts left by one. The new outcome enters bit 0 (1 = taken, 0 = not taken) and only the 12 newest outcomes are kept.
- R3: The global component's 2-bit counter is addressed by the shared history. It saturates at 0 and 3, counts up on taken and down on not-taken, and predicts taken when its value is 2 or 3.
- R4: The per-branch history is addressed by `pc[11:2]`. On update, the outcome is shifted into bit 0 of that entry and only 10 outcomes are kept.
- R5: The local component's 3-bit counter is addressed by the selected 10-bit history. It saturates at 0 and 7 and predicts taken when its value is 4 or more.
- R6: The selector counter is addressed by the shared history. A value of 2 or 3 selects the global prediction (`lk_use_global` = 1). A value of 0 or 1 selects the local prediction.
- R7: The selector counter steps up (saturating at 3) when only the global component was correct. It steps down (saturating at 0) when only the local component was correct. It is unchanged when both components were right or both were wrong.
- R8: A lookup is combinational and reflects the state before any update applied at the same clock edge.
- R9: When `up_valid` is 0, no table and no history changes, whatever values `up_pc` and `up_taken` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | 32 | Program counter of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_use_global | output | 1 | 1 when the global component supplied the prediction |
| up_valid | input | 1 | Applies a resolved branch this cycle |
| up_pc | input | 32 | Program counter of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The in-RTL assertions check the following on every cycle: the shared history shift, the per-branch history insert, the step and saturation rules of the counters, that the selector holds when the two components agree in correctness, and that nothing moves on an idle cycle. Only the bench scenarios can show how these rules combine into actual predictions. The bench covers learning an always-taken branch, learning an alternating pattern through local history, and the selector's shift between components over a long mixed stream. In every scenario the bench checks the output against a reference model that it builds from the requirements.

// File: rtl/tourney_bp.sv
module tourney_bp #(
  parameter int PC_W = 32,
  parameter int GH_W = 12,
  parameter int LT_W = 10,
  parameter int LH_W = 10,
  parameter int GC_W = 2,
  parameter int LC_W = 3,
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic            lk_use_global,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  localparam int GN  = 1 << GH_W;
  localparam int LTN = 1 << LT_W;
  localparam int LCN = 1 << LH_W;
  localparam logic [GC_W-1:0] GC_MAX = '1;
  localparam logic [LC_W-1:0] LC_MAX = '1;
  localparam logic [CH_W-1:0] CH_MAX = '1;
  localparam logic [GC_W-1:0] GC_RST = GC_W'((1 << (GC_W-1)) - 1);
  localparam logic [LC_W-1:0] LC_RST = LC_W'((1 << (LC_W-1)) - 1);
  localparam logic [CH_W-1:0] CH_RST = CH_W'((1 << (CH_W-1)) - 1);

  logic [GH_W-1:0] ghist;
  logic [GC_W-1:0] gctr    [GN];
  logic [CH_W-1:0] chooser [GN];
  logic [LH_W-1:0] lhist   [LTN];
  logic [LC_W-1:0] lctr    [LCN];

  logic [LT_W-1:0] lk_li;
  assign lk_li         = lk_pc[LT_W+1:2];
  assign lk_use_global = chooser[ghist][CH_W-1];
  assign lk_taken      = lk_use_global ? gctr[ghist][GC_W-1] : lctr[lhist[lk_li]][LC_W-1];

  logic [LT_W-1:0] up_li;
  logic [LH_W-1:0] up_lh;
  logic [GC_W-1:0] gc_cur, gc_nxt;
  logic [LC_W-1:0] lc_cur, lc_nxt;
  logic [CH_W-1:0] ch_cur, ch_nxt;
  logic            g_ok, l_ok;

  assign up_li  = up_pc[LT_W+1:2];
  assign up_lh  = lhist[up_li];
  assign gc_cur = gctr[ghist];
  assign lc_cur = lctr[up_lh];
  assign ch_cur = chooser[ghist];
  assign g_ok   = gc_cur[GC_W-1] == up_taken;
  assign l_ok   = lc_cur[LC_W-1] == up_taken;

  always_comb begin
    if (up_taken) gc_nxt = (gc_cur == GC_MAX) ? gc_cur : gc_cur + 1'b1;
    else          gc_nxt = (gc_cur == '0)     ? gc_cur : gc_cur - 1'b1;
    if (up_taken) lc_nxt = (lc_cur == LC_MAX) ? lc_cur : lc_cur + 1'b1;
    else          lc_nxt = (lc_cur == '0)     ? lc_cur : lc_cur - 1'b1;
    ch_nxt = ch_cur;
    if (g_ok && !l_ok && ch_cur != CH_MAX) ch_nxt = ch_cur + 1'b1;
    if (l_ok && !g_ok && ch_cur != '0)     ch_nxt = ch_cur - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghist <= '0;
      for (int i = 0; i < GN; i++) begin
        gctr[i]    <= GC_RST;
        chooser[i] <= CH_RST;
      end
      for (int i = 0; i < LTN; i++) lhist[i] <= '0;
      for (int i = 0; i < LCN; i++) lctr[i] <= LC_RST;
    end else if (up_valid) begin
      gctr[ghist]    <= gc_nxt;
      chooser[ghist] <= ch_nxt;
      lctr[up_lh]    <= lc_nxt;
      lhist[up_li]   <= {up_lh[LH_W-2:0], up_taken};
      ghist          <= {ghist[GH_W-2:0], up_taken};
    end
  end

  a_r2_ghist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ghist == {$past(ghist[GH_W-2:0]), $past(up_taken)});

  a_r4_lhist_insert: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> lhist[$past(up_li)][0] == $past(up_taken));

  a_r3_gctr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken && gc_cur != GC_MAX) |=> gctr[$past(ghist)] == $past(gc_cur) + 1'b1);

  a_r5_lctr_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken && lc_cur == LC_MAX) |=> lctr[$past(up_lh)] == LC_MAX);

  a_r7_chooser_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && (g_ok == l_ok)) |=> chooser[$past(ghist)] == $past(ch_cur));

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghist));
endmodule

// File: tb/sim_tourney_bp.sv
`timescale 1ns/1ps
module sim_tourney_bp;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] lk_pc = '0;
  logic        lk_taken, lk_use_global;
  logic        up_valid = 0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 0;

  always #10 clk = ~clk;

  tourney_bp u0 (.clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
                 .lk_use_global(lk_use_global), .up_valid(up_valid), .up_pc(up_pc),
                 .up_taken(up_taken));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int m_g[4096], m_c[4096], m_l[1024], m_h[1024];
  int m_gh;

  bit    q_pred[$];
  bit    q_pick[$];
  string q_tag[$];

  task automatic model_reset();
    for (int i = 0; i < 4096; i++) begin m_g[i] = 1; m_c[i] = 1; end
    for (int i = 0; i < 1024; i++) begin m_l[i] = 3; m_h[i] = 0; end
    m_gh = 0;
  endtask

  task automatic model_update(input logic [31:0] pc, input bit t);
    int li, lh; bit gp, lp;
    li = int'(pc[11:2]); lh = m_h[li];
    gp = m_g[m_gh] >= 2; lp = m_l[lh] >= 4;
    if ((gp == t) && (lp != t) && m_c[m_gh] < 3) m_c[m_gh]++;
    if ((lp == t) && (gp != t) && m_c[m_gh] > 0) m_c[m_gh]--;
    if (t) begin if (m_g[m_gh] < 3) m_g[m_gh]++; if (m_l[lh] < 7) m_l[lh]++; end
    else   begin if (m_g[m_gh] > 0) m_g[m_gh]--; if (m_l[lh] > 0) m_l[lh]--; end
    m_h[li] = ((lh << 1) | int'(t)) & 'h3FF;
    m_gh = ((m_gh << 1) | int'(t)) & 'hFFF;
  endtask

  // driver: one cycle with a lookup and an optional update; expected pushed first
  task automatic step(input logic [31:0] pc, input bit upd, input bit t, input string tag);
    bit pick, pred;
    @(negedge clk);
    lk_pc = pc; up_pc = pc; up_valid = upd; up_taken = t;
    pick = m_c[m_gh] >= 2;
    pred = pick ? (m_g[m_gh] >= 2) : (m_l[m_h[int'(pc[11:2])]] >= 4);
    q_pred.push_back(pred); q_pick.push_back(pick); q_tag.push_back(tag);
    if (upd) model_update(pc, t);
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    #2;
    if (q_pred.size() > 0) begin
      bit ep, ek; string tg;
      ep = q_pred.pop_front(); ek = q_pick.pop_front(); tg = q_tag.pop_front();
      n_chk++;
      if (lk_taken !== ep || lk_use_global !== ek) begin
        n_bad++;
        $display("FAIL %s: pred/pick actual %b/%b expected %b/%b", tg, lk_taken, lk_use_global, ep, ek);
      end
    end
  end

  task automatic direct(input logic [31:0] pc, input bit ep, input bit ek, input string tag);
    @(negedge clk);
    lk_pc = pc; up_valid = 0;
    #2;
    n_chk++;
    if (lk_taken !== ep || lk_use_global !== ek) begin
      n_bad++;
      $display("FAIL %s: pred/pick actual %b/%b expected %b/%b", tag, lk_taken, lk_use_global, ep, ek);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state, several PCs
    direct(32'h0000_0000, 0, 0, "R1");
    direct(32'h0000_0FFC, 0, 0, "R1");
    for (int i = 0; i < 4; i++) step(32'h40 + i * 4, 0, 0, "R1");
    // R9: idle cycles with taken on the update pins change nothing
    for (int i = 0; i < 6; i++) step(32'h100, 0, 1, "R9");
    direct(32'h100, 0, 0, "R9");
    // R2 R3 R5: an always-taken branch is learned
    for (int i = 0; i < 24; i++) step(32'h100, 1, 1, "R3_R5");
    direct(32'h100, 1, m_c[m_gh] >= 2, "R2_taken_learned");
    // R4: alternating branch learned through its own history
    for (int i = 0; i < 40; i++) step(32'h204, 1, i[0], "R4");
    // R6 R7 R8: mixed stream over several branches
    for (int i = 0; i < 2000; i++) begin
      int sel; bit t;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sel = int'(lfsr[2:0]);
      t = (sel < 3) ? ((i % 4) != 3) : (sel == 7 ? lfsr[5] : ((i % 2) == 0));
      step(32'h3000 + sel * 8, 1, t, "R6_R7_R8");
    end
    // R9 again after training, then R8 lookup of other PC while updating
    for (int i = 0; i < 4; i++) step(32'h3008, 0, ~lfsr[0], "R9");
    for (int i = 0; i < 8; i++) step(32'h3010, 1, 0, "R8");
    @(negedge clk); up_valid = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule